// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers single-cycle event pulses from four power-delivery ports and holds them in one sticky event register per port. Each port also has an enable register for its event bits. A port raises its bit in a summary register when any held event is also enabled. A separate device event tracks changes of a supply/temperature status word. The active-low interrupt output is registered and goes low while any summary bit is set.

Software uses a small register port: an address, a read strobe with registered read data, and a write strobe for the enable registers. Reading a port's event register returns the held bits and clears them in the same cycle. Reading the device status word clears the device event. An event pulse that arrives in the same cycle as a clearing read is kept, so no event is lost. A classification-done pulse is accepted only after that port has reported a good detection signature.

Top module: `evt_irq_agg`

## Requirements
- R1: `irq_no` is registered. One cycle after the summary value is non-zero it is 0. One cycle after the summary value is zero it is 1.
- R2: Address 0x00 reads the summary. Bit p (p = 0..3) is port p's interrupt and bit 4 is the device event. All other bits read 0.
- R3: Event bit positions within a port are: bit 0 overload cut, bit 1 classification done, bit 2 detection complete, bit 3 power-good change, bit 4 power enabled. A port's interrupt is the OR of each held event bit ANDed with the same bit of its enable register. An enable bit of 1 lets that event through. The enable register for port p is written at address 0x0A+p through `wr_en_i`/`wr_data_i` and reads back at that address.
- R4: A read of address 0x02+p returns port p's held event bits on `rd_data_o` one cycle after `rd_en_i`, and clears those bits at the same clock edge.
- R5: An event pulse in the same cycle as a clearing read of its port is held afterwards. It is not part of that read's data.
- R6: A registered copy of `dev_stat_i` resets to 0. The device event sets in any cycle where `dev_stat_i` differs from that copy. A read of address 0x01 returns the copy and clears the device event.
- R7: A classification-done pulse is ignored unless a `det_good_i` pulse for that port arrived in an earlier cycle. Each accepted classification-done consumes that earlier good detection.
- R8: Address 0x06+p returns `port_stat_i` of port p, zero-extended to 8 bits.
- R9: After reset all events, enable bits, device event and good-detection flags are 0, `rd_data_o` is 0 and `irq_no` is 1.
- R10: Reading the summary, status, enable or an unmapped address (0x0E..0x1F) clears nothing. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_evt_i | input | 20 | Event pulses, 5 bits per port, port p at bits [5p+4:5p] |
| det_good_i | input | 4 | Good detection signature pulse, one per port |
| port_stat_i | input | 20 | Port status word, 5 bits per port |
| dev_stat_i | input | 8 | Supply/temperature status word |
| addr_i | input | 5 | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (enable registers) |
| wr_data_i | input | 5 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench lands an event pulse in the same cycle as a clearing read. A design that cleared with priority over setting would lose that event, and the second read would return 0. Enabled and disabled events are both checked at `irq_no`: a design that ignored the enable would pull the pin low for a disabled event. A classification-done pulse is sent with no prior good detection, and again after one good detection has already been used. A design without that gating would latch the event. Reads of the summary, status, enable and unmapped addresses are made before the event register is read. A decoder that cleared on the wrong address would then return an empty event register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int EVT_W  = 5;
  localparam int STAT_W = 5;
  localparam int DEV_W  = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  typedef enum int {
    EV_OVL   = 0,
    EV_CLS   = 1,
    EV_DET   = 2,
    EV_PGCHG = 3,
    EV_PEN   = 4
  } evt_bit_e;

  localparam int SUM_ADDR = 0;
  localparam int DEV_ADDR = 1;
  localparam int EVT_BASE = 2;
endpackage

// File: rtl/irq_port_evt.sv
module irq_port_evt
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             det_good_i,
  input  logic             clr_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] mask_d_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             armed_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_q, mask_q, evt_acc;
  logic             armed_q, cls_ok;

  assign cls_ok = evt_i[EV_CLS] & armed_q;

  always_comb begin
    evt_acc         = evt_i;
    evt_acc[EV_CLS] = cls_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      // set wins over clear: a pulse during a clearing read survives
      evt_q <= (evt_q & ~{EVT_W{clr_i}}) | evt_acc;
      if (mask_we_i) mask_q <= mask_d_i;
      if (det_good_i)  armed_q <= 1'b1;
      else if (cls_ok) armed_q <= 1'b0;
    end
  end

  assign evt_o   = evt_q;
  assign mask_o  = mask_q;
  assign armed_o = armed_q;
  assign irq_o   = |(evt_q & mask_q);
endmodule

// File: rtl/irq_dev_evt.sv
module irq_dev_evt
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] dev_stat_i,
  input  logic             clr_i,
  output logic [DEV_W-1:0] stat_o,
  output logic             evt_o
);
  logic [DEV_W-1:0] stat_q;
  logic             evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      stat_q <= dev_stat_i;
      evt_q  <= (evt_q & ~clr_i) | (dev_stat_i != stat_q);
    end
  end

  assign stat_o = stat_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       rd_en_i,
  input  logic                       wr_en_i,
  input  logic [DATA_W-1:0]          summary_i,
  input  logic [DEV_W-1:0]           dev_stat_i,
  input  logic [NUM_PORTS*EVT_W-1:0] evt_i,
  input  logic [NUM_PORTS*EVT_W-1:0] mask_i,
  input  logic [NUM_PORTS*STAT_W-1:0] stat_i,
  output logic [NUM_PORTS-1:0]       evt_clr_o,
  output logic [NUM_PORTS-1:0]       mask_we_o,
  output logic                       dev_clr_o,
  output logic [DATA_W-1:0]          rd_data_o
);
  localparam int STAT_BASE = EVT_BASE + NUM_PORTS;
  localparam int MASK_BASE = STAT_BASE + NUM_PORTS;

  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    rd_val    = '0;
    evt_clr_o = '0;
    mask_we_o = '0;
    dev_clr_o = rd_en_i && (addr_i == ADDR_W'(DEV_ADDR));
    if (addr_i == ADDR_W'(SUM_ADDR)) rd_val = summary_i;
    if (addr_i == ADDR_W'(DEV_ADDR)) rd_val = DATA_W'(dev_stat_i);
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == ADDR_W'(EVT_BASE + p)) begin
        rd_val       = DATA_W'(evt_i[p*EVT_W +: EVT_W]);
        evt_clr_o[p] = rd_en_i;
      end
      if (addr_i == ADDR_W'(STAT_BASE + p))
        rd_val = DATA_W'(stat_i[p*STAT_W +: STAT_W]);
      if (addr_i == ADDR_W'(MASK_BASE + p)) begin
        rd_val       = DATA_W'(mask_i[p*EVT_W +: EVT_W]);
        mask_we_o[p] = wr_en_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_val;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*EVT_W-1:0]  port_evt_i,
  input  logic [NUM_PORTS-1:0]        det_good_i,
  input  logic [NUM_PORTS*STAT_W-1:0] port_stat_i,
  input  logic [DEV_W-1:0]            dev_stat_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        rd_en_i,
  input  logic                        wr_en_i,
  input  logic [EVT_W-1:0]            wr_data_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        irq_no
);
  localparam int DEV_BIT = NUM_PORTS;

  logic [NUM_PORTS*EVT_W-1:0] evt_flat, mask_flat;
  logic [NUM_PORTS-1:0]       port_irq, evt_clr, mask_we, armed_flat;
  logic [DEV_W-1:0]           dev_stat_q;
  logic                       dev_evt_q, dev_clr;
  logic [DATA_W-1:0]          summary;
  logic                       irq_nq;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    irq_port_evt i_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (port_evt_i[p*EVT_W +: EVT_W]),
      .det_good_i (det_good_i[p]),
      .clr_i      (evt_clr[p]),
      .mask_we_i  (mask_we[p]),
      .mask_d_i   (wr_data_i),
      .evt_o      (evt_flat[p*EVT_W +: EVT_W]),
      .mask_o     (mask_flat[p*EVT_W +: EVT_W]),
      .armed_o    (armed_flat[p]),
      .irq_o      (port_irq[p])
    );
  end

  irq_dev_evt i_dev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_stat_i (dev_stat_i),
    .clr_i      (dev_clr),
    .stat_o     (dev_stat_q),
    .evt_o      (dev_evt_q)
  );

  always_comb begin
    summary                   = '0;
    summary[NUM_PORTS-1:0]    = port_irq;
    summary[DEV_BIT]          = dev_evt_q;
  end

  irq_reg_port #(.NUM_PORTS(NUM_PORTS)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .summary_i  (summary),
    .dev_stat_i (dev_stat_q),
    .evt_i      (evt_flat),
    .mask_i     (mask_flat),
    .stat_i     (port_stat_i),
    .evt_clr_o  (evt_clr),
    .mask_we_o  (mask_we),
    .dev_clr_o  (dev_clr),
    .rd_data_o  (rd_data_o)
  );

  // registered pin: no glitch from the combinational summary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_nq <= 1'b1;
    else         irq_nq <= ~|summary;
  end

  assign irq_no = irq_nq;
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_PORTS*EVT_W-1:0] port_evt_i,
  input logic [DEV_W-1:0]           dev_stat_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       rd_en_i,
  input logic                       irq_no,
  input logic [NUM_PORTS*EVT_W-1:0] evt_flat,
  input logic [NUM_PORTS*EVT_W-1:0] mask_flat,
  input logic [NUM_PORTS-1:0]       armed_flat,
  input logic [DEV_W-1:0]           dev_stat_q,
  input logic                       dev_evt_q
);
  logic any_en;
  always_comb begin
    any_en = dev_evt_q;
    for (int p = 0; p < NUM_PORTS; p++)
      any_en = any_en | (|(evt_flat[p*EVT_W +: EVT_W] & mask_flat[p*EVT_W +: EVT_W]));
  end

  a_r1_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |=> !irq_no);

  a_r3_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en |=> irq_no);

  a_r6_dev_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_stat_i != dev_stat_q) |=> dev_evt_q);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    a_r4_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == ADDR_W'(EVT_BASE + p) && port_evt_i[p*EVT_W +: EVT_W] == '0)
      |=> evt_flat[p*EVT_W +: EVT_W] == '0);

    a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_evt_i[p*EVT_W + EV_OVL] |=> evt_flat[p*EVT_W + EV_OVL]);

    a_r7_cls_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_evt_i[p*EVT_W + EV_CLS] && !armed_flat[p] &&
       !(rd_en_i && addr_i == ADDR_W'(EVT_BASE + p)))
      |=> evt_flat[p*EVT_W + EV_CLS] == $past(evt_flat[p*EVT_W + EV_CLS]));
  end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .port_evt_i (port_evt_i),
  .dev_stat_i (dev_stat_i),
  .addr_i     (addr_i),
  .rd_en_i    (rd_en_i),
  .irq_no     (irq_no),
  .evt_flat   (evt_flat),
  .mask_flat  (mask_flat),
  .armed_flat (armed_flat),
  .dev_stat_q (dev_stat_q),
  .dev_evt_q  (dev_evt_q)
);

// File: tb/test_evt_irq_agg.sv
`timescale 1ns/1ps
module test_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] port_evt = '0;
  logic [3:0]  det_good = '0;
  logic [19:0] port_stat = '0;
  logic [7:0]  dev_stat = '0;
  logic [4:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_n;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_agg i_evt_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .port_evt_i(port_evt), .det_good_i(det_good),
    .port_stat_i(port_stat), .dev_stat_i(dev_stat), .addr_i(addr),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_no(irq_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wr(input logic [4:0] a, input logic [4:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int p, input logic [4:0] bits);
    @(negedge clk); port_evt[p*5 +: 5] = bits;
    @(negedge clk); port_evt = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R9 irq_no", {7'd0, irq_n}, 8'h01);
    check("R9 rd_data", rd_data, 8'h00);
    rd(5'h00, d); check("R9 summary", d, 8'h00);
    rd(5'h0A, d); check("R9 enable", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    pulse(0, 5'h01);
    @(negedge clk);
    check("R3 disabled event keeps irq high", {7'd0, irq_n}, 8'h01);
    rd(5'h00, d); check("R3 disabled summary", d, 8'h00);
    wr(5'h0A, 5'h01);
    @(negedge clk);
    check("R1 irq low after enable", {7'd0, irq_n}, 8'h00);
    rd(5'h0A, d); check("R3 enable readback", d, 8'h01);
    rd(5'h00, d); check("R2 summary port0", d, 8'h01);
  endtask

  task automatic t_cor();
    logic [7:0] d;
    rd(5'h02, d); check("R4 event read", d, 8'h01);
    @(negedge clk);
    check("R4 irq released", {7'd0, irq_n}, 8'h01);
    rd(5'h02, d); check("R4 cleared", d, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    wr(5'h0B, 5'h1F);
    pulse(1, 5'h08);
    @(negedge clk); addr = 5'h03; rd_en = 1'b1; port_evt[5 +: 5] = 5'h10;
    @(negedge clk); rd_en = 1'b0; port_evt = '0; d = rd_data;
    check("R5 read excludes same-cycle event", d, 8'h08);
    rd(5'h03, d); check("R5 same-cycle event kept", d, 8'h10);
  endtask

  task automatic t_cls();
    logic [7:0] d;
    wr(5'h0C, 5'h1F);
    pulse(2, 5'h02);
    rd(5'h04, d); check("R7 cls without detection ignored", d, 8'h00);
    @(negedge clk); det_good[2] = 1'b1;
    @(negedge clk); det_good = '0;
    pulse(2, 5'h02);
    rd(5'h04, d); check("R7 cls after detection", d, 8'h02);
    pulse(2, 5'h02);
    rd(5'h04, d); check("R7 detection consumed", d, 8'h00);
  endtask

  task automatic t_dev();
    logic [7:0] d;
    @(negedge clk); dev_stat = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    check("R1 irq on device event", {7'd0, irq_n}, 8'h00);
    rd(5'h00, d); check("R2 summary device bit", d, 8'h10);
    rd(5'h01, d); check("R6 device status", d, 8'h5A);
    @(negedge clk);
    check("R6 device event cleared", {7'd0, irq_n}, 8'h01);
    rd(5'h00, d); check("R6 summary clear", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    port_stat[15 +: 5] = 5'h15;
    pulse(3, 5'h04);
    @(negedge clk);
    check("R3 detection complete disabled", {7'd0, irq_n}, 8'h01);
    rd(5'h09, d); check("R8 port3 status", d, 8'h15);
    rd(5'h00, d); check("R10 summary read", d, 8'h00);
    rd(5'h0D, d); check("R10 enable read", d, 8'h00);
    rd(5'h0F, d); check("R10 unmapped reads zero", d, 8'h00);
    rd(5'h05, d); check("R10 event survives other reads", d, 8'h04);
  endtask

  task automatic t_multi();
    logic [7:0] d;
    @(negedge clk); port_evt[0 +: 5] = 5'h01; port_evt[10 +: 5] = 5'h01;
    @(negedge clk); port_evt = '0;
    rd(5'h00, d); check("R2 two ports", d, 8'h05);
    rd(5'h02, d); rd(5'h04, d);
    @(negedge clk);
    check("R1 irq high after clearing", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_cor();
    t_sticky();
    t_cls();
    t_dev();
    t_status();
    t_multi();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule